// File: doc/BRIEF.md
# I2C Master SCL Clock Generator

This block produces the serial clock for an I2C master from a fast system clock. A 5-bit divisor code and a standard/fast mode select set the period. The generator pulls the bus line low through an open-drain output enable, and it releases the line for the high phase. It reads the line back, so a slave that holds SCL low lengthens the low phase, and the high phase is always timed in full from the moment the line is really seen high.

Two single-cycle strobes come out with the clock. One marks the cycle in which the generator starts to drive the line low. The other marks the first cycle in which the line is sampled high. A byte shifter next to this block uses them to launch and capture data bits. Start and stop conditions, arbitration, shifting and register access are handled by other blocks.

Top module: `i2c_scl_gen`

## Requirements
- R1: While `enable` is low or `div_code` is 0, 1 or 2, the generator drives no clock. From the next cycle `scl_oe` is 0, and neither strobe is asserted.
- R2: In standard mode (`fast_mode` = 0) with a valid code c, the line is low for 4·c cycles and high for 4·c cycles, so one period is 8·c cycles.
- R3: In fast mode with a valid code c other than 5, the line is low for 2·c cycles and high for 2·c cycles, so one period is 4·c cycles.
- R4: In fast mode with code 5, one period is 10 cycles: 4 cycles high and 6 cycles low.
- R5: `fall_stb` is high for exactly one cycle, and that cycle is the first one in which `scl_oe` is 1 in a low phase. It is never high at any other time.
- R6: `rise_stb` is high for exactly one cycle, and that cycle is the first one after a release in which `scl_in` reads 1. The high phase is timed from that cycle.
- R7: If the line is held low by another device after the generator releases it, the measured low time grows by the length of the hold, and the following high time keeps its nominal length.
- R8: A change of `div_code` or `fast_mode` between two valid settings has no effect on the period in progress. It takes effect from the next falling edge of SCL.
- R9: During reset `scl_oe`, `rise_stb` and `fall_stb` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run request for the clock generator |
| fast_mode | input | 1 | 1 selects fast mode, 0 selects standard mode |
| div_code | input | CODE_W | Divisor code; 0 to 2 are rejected |
| scl_in | input | 1 | Sampled level of the SCL line |
| scl_oe | output | 1 | 1 pulls SCL low; 0 releases it |
| rise_stb | output | 1 | First cycle SCL is seen high after release |
| fall_stb | output | 1 | First cycle SCL is driven low |

## Verification
A down-counter that loads the wrong phase length shows at the ports within one period, as a low or high time that is too short or too long. The bench measures each of these times and compares it with the value expected for the settings in force. A phase state that does not move on shows as a line held low or released for too long, or as a missing strobe. If the generator keeps running after it is disabled, `scl_oe` is still active one cycle after the disabling input changes. A setting that is latched in the wrong cycle is seen in the single period that straddles the change.

// File: rtl/i2c_scl_gen.sv
module i2c_scl_gen #(
  parameter int CODE_W   = 5,
  parameter int MIN_CODE = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              fast_mode,
  input  logic [CODE_W-1:0] div_code,
  input  logic              scl_in,
  output logic              scl_oe,
  output logic              rise_stb,
  output logic              fall_stb
);
  localparam int CNT_W = CODE_W + 2;

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_WAIT, S_HIGH} phase_t;

  phase_t           state;
  logic [CNT_W-1:0] cnt, hi_q, lo_next, hi_next;
  logic             run, go_low;

  assign run = enable && (div_code >= CODE_W'(MIN_CODE));

  always_comb begin
    if (!fast_mode) begin
      lo_next = {div_code, 2'b00};
      hi_next = {div_code, 2'b00};
    end else if (div_code == CODE_W'(5)) begin
      lo_next = CNT_W'(6);
      hi_next = CNT_W'(4);
    end else begin
      lo_next = {1'b0, div_code, 1'b0};
      hi_next = {1'b0, div_code, 1'b0};
    end
  end

  assign go_low   = (state == S_IDLE) || (state == S_HIGH && cnt == '0);
  assign rise_stb = run && (state == S_WAIT) && scl_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      hi_q     <= '0;
      scl_oe   <= 1'b0;
      fall_stb <= 1'b0;
    end else begin
      fall_stb <= 1'b0;
      if (!run) begin
        state  <= S_IDLE;
        cnt    <= '0;
        scl_oe <= 1'b0;
      end else if (go_low) begin
        state    <= S_LOW;
        scl_oe   <= 1'b1;
        fall_stb <= 1'b1;
        cnt      <= lo_next - 1'b1;
        hi_q     <= hi_next;
      end else begin
        case (state)
          S_LOW:
            if (cnt == '0) begin
              state  <= S_WAIT;
              scl_oe <= 1'b0;
            end else begin
              cnt <= cnt - 1'b1;
            end
          S_WAIT:
            if (scl_in) begin
              state <= S_HIGH;
              cnt   <= hi_q - 2'd2;
            end
          S_HIGH:
            cnt <= cnt - 1'b1;
          default:
            state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_scl_gen_chk.sv
module i2c_scl_gen_chk #(
  parameter int CODE_W   = 5,
  parameter int MIN_CODE = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic [CODE_W-1:0] div_code,
  input logic              scl_in,
  input logic              scl_oe,
  input logic              rise_stb,
  input logic              fall_stb
);
  // R1
  halt_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable || div_code < CODE_W'(MIN_CODE)) |=> !scl_oe);

  // R5
  fall_on_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> fall_stb);

  // R5
  fall_only_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |-> (scl_oe && !$past(scl_oe)));

  // R6
  rise_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> (scl_in && !scl_oe));

  // R5
  strobes_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_stb, fall_stb}));
endmodule

bind i2c_scl_gen i2c_scl_gen_chk #(.CODE_W(CODE_W), .MIN_CODE(MIN_CODE)) chk_i (
  .clk(clk), .rst_n(rst_n), .enable(enable), .div_code(div_code),
  .scl_in(scl_in), .scl_oe(scl_oe), .rise_stb(rise_stb), .fall_stb(fall_stb)
);

// File: tb/i2c_scl_gen_tb_top.sv
module i2c_scl_gen_tb_top;
  logic       clk = 1'b0, rst_n = 1'b0, enable = 1'b0, fast_mode = 1'b0, hold_low = 1'b0;
  logic [4:0] div_code = 5'd0;
  logic       scl_oe, rise_stb, fall_stb, scl_in;

  assign scl_in = ~scl_oe & ~hold_low;
  always #5 clk = ~clk;

  i2c_scl_gen dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .fast_mode(fast_mode),
    .div_code(div_code), .scl_in(scl_in), .scl_oe(scl_oe),
    .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  typedef struct {int lo; int hi; string tag;} per_t;
  per_t exp_q[$];
  per_t e;
  int   n_chk = 0, n_bad = 0;
  bit   done = 0;
  int   lo_c = 0, hi_c = 0;
  bit   act, prev_act = 0, prev_in = 1, prev_oe = 0, want_rise, want_fall;

  function automatic void check(input bit ok, input string tag, input string what,
                                input int act_v, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act_v, exp_v);
    end
  endfunction

  function automatic void nominal(input int code, input bit fast, output int lo, output int hi);
    if (!fast) begin lo = 4 * code; hi = 4 * code; end
    else if (code == 5) begin lo = 6; hi = 4; end
    else begin lo = 2 * code; hi = 2 * code; end
  endfunction

  // monitor: measures each period and compares with the scoreboard
  always @(negedge clk) begin
    act = rst_n && enable && (div_code >= 5'd3);
    if (!act) begin
      lo_c = 0; hi_c = 0;
    end else begin
      if (fall_stb && lo_c > 0 && hi_c > 0) begin
        if (exp_q.size() == 0) check(1'b0, "R2", "unexpected period", lo_c + hi_c, 0);
        else begin
          e = exp_q.pop_front();
          check(lo_c == e.lo, e.tag, "low time", lo_c, e.lo);
          check(hi_c == e.hi, e.tag, "high time", hi_c, e.hi);
          check(lo_c + hi_c == e.lo + e.hi, e.tag, "period", lo_c + hi_c, e.lo + e.hi);
        end
      end
      if (fall_stb) begin lo_c = 0; hi_c = 0; end
      if (!scl_in) lo_c++; else hi_c++;
    end
    if (act && prev_act) begin
      want_rise = !prev_in && scl_in && !scl_oe;
      if (want_rise || rise_stb) check(rise_stb == want_rise, "R6", "rise strobe", rise_stb, want_rise);
      want_fall = scl_oe && !prev_oe;
      if (want_fall || fall_stb) check(fall_stb == want_fall, "R5", "fall strobe", fall_stb, want_fall);
    end
    prev_in = scl_in; prev_oe = scl_oe; prev_act = act;
  end

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic run_cfg(input int code, input bit fast, input int n, input string tag);
    int lo, hi;
    @(posedge clk); #1;
    div_code = 5'(code); fast_mode = fast; enable = 1'b1;
    nominal(code, fast, lo, hi);
    repeat (n) exp_q.push_back('{lo, hi, tag});
    drain();
  endtask

  task automatic stop_gen();
    @(posedge clk); #1; enable = 1'b0;
    repeat (3) @(posedge clk);
  endtask

  task automatic quiet_window(input int code, input bit fast);
    int edges = 0;
    @(posedge clk); #1;
    div_code = 5'(code); fast_mode = fast; enable = 1'b1;
    repeat (60) begin
      @(negedge clk);
      if (scl_oe || fall_stb || rise_stb) edges++;
    end
    check(edges == 0, "R1", $sformatf("activity with code %0d", code), edges, 0);
    stop_gen();
  endtask

  task automatic abort_mid(input bit by_code);
    @(posedge clk); #1;
    div_code = 5'd4; fast_mode = 1'b0; enable = 1'b1;
    do @(negedge clk); while (!scl_oe);
    @(posedge clk); #1;
    if (by_code) div_code = 5'd2; else enable = 1'b0;
    @(posedge clk); @(negedge clk);
    check(!scl_oe && !fall_stb, "R1", "drive after stop", scl_oe, 0);
    stop_gen();
  endtask

  initial begin
    int codes[4] = '{3, 5, 6, 31};
    repeat (4) @(negedge clk);
    // R9
    check(!scl_oe, "R9", "scl_oe in reset", scl_oe, 0);
    check(!fall_stb && !rise_stb, "R9", "strobes in reset", fall_stb | rise_stb, 0);
    @(posedge clk); #1; rst_n = 1'b1;

    foreach (codes[i]) begin
      run_cfg(codes[i], 1'b0, 3, "R2");
      stop_gen();
      run_cfg(codes[i], 1'b1, 3, (codes[i] == 5) ? "R4" : "R3");
      stop_gen();
    end

    // R8: switch settings while a period runs
    run_cfg(6, 1'b0, 2, "R2");
    @(posedge clk); #1;
    exp_q.push_back('{24, 24, "R8"});
    div_code = 5'd3; fast_mode = 1'b1;
    repeat (3) exp_q.push_back('{6, 6, "R8"});
    drain();
    stop_gen();

    // R7: slave holds the line low for 5 cycles after release
    run_cfg(5, 1'b1, 1, "R4");
    @(posedge clk); #1;
    hold_low = 1'b1;
    exp_q.push_back('{11, 4, "R7"});
    forever begin
      if (!scl_oe) break;
      @(posedge clk); #1;
    end
    repeat (5) begin @(posedge clk); #1; end
    hold_low = 1'b0;
    repeat (2) exp_q.push_back('{6, 4, "R4"});
    drain();
    stop_gen();

    // R1: rejected codes and mid-run stops
    for (int c = 0; c < 3; c++) begin
      quiet_window(c, 1'b0);
      quiet_window(c, 1'b1);
    end
    abort_mid(1'b0);
    abort_mid(1'b1);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      check(1'b0, "R2", "watchdog expired", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule